// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps the coherence state of one private write-back cache on a shared snooping bus. It holds a tag and a line state (Invalid, Shared, Exclusive, Modified) for every set of a small direct-mapped cache. It turns processor reads and writes into bus transactions: read, read-for-ownership, invalidate and write-back of a dirty victim. It also watches the transactions that other caches put on the bus. It answers them with a wired-OR "copy present" indication and a "dirty data supplied" indication, and it downgrades or drops its own copy. A parameter removes the Exclusive-clean state and turns the controller into a three-state (MSI) one.

The processor side is a valid/ready stream. The requester holds `cpu_req_valid`, write flag and address steady until `cpu_req_ready` is high on a clock edge. Hits complete in the cycle they are presented. Misses complete in the cycle the bus grant arrives. The bus side is also valid/ready. `bus_req_valid` stays high until `bus_grant`, and the command and address change only when a snoop to the same set has altered the line, in which case the request is withdrawn for that cycle and re-evaluated. The snoop port has no back-pressure: one transaction per `snoop_valid` cycle, with the response registered and presented one cycle later, inside the two-cycle response window. Line addresses exclude the byte offset: the low `log2(SETS)` bits select the set and the rest form the tag.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first processor access to any address issues a bus request and is not ready.
- R2: A read miss drives `bus_req_cmd` = 0 (read) with the requested line address and completes (`cpu_req_ready` high) in the cycle `bus_grant` is high.
- R3: In MESI mode a read fill becomes Exclusive when `bus_shared_in` is low in the grant cycle and Shared when it is high. A Shared line that is written issues `bus_req_cmd` = 2 (invalidate).
- R4: A write to a line held Exclusive or Modified completes in the cycle it is presented with no bus request, and the line becomes Modified.
- R5: A write miss drives `bus_req_cmd` = 1 (read-for-ownership). A granted read-for-ownership or invalidate leaves the line Modified.
- R6: A snooped read (`snoop_cmd` = 0) that hits a valid line raises `snoop_shared_out` in the next cycle, and also raises `snoop_supply_out` if the line was Modified. The line becomes Shared.
- R7: A snooped read-for-ownership (1) or invalidate (2) that hits raises `snoop_shared_out` in the next cycle, and `snoop_supply_out` if the line was Modified. The line becomes Invalid.
- R8: A snooped write-back (3), or a snoop whose tag differs from the resident tag, gives no response and leaves the line unchanged.
- R9: A miss to a set whose resident line is Modified under another tag first issues `bus_req_cmd` = 3 (write-back) with the resident line address. That transaction does not complete the processor request, and the miss command follows once it is granted.
- R10: In a cycle with `snoop_valid` to the same set as the pending processor request, `bus_req_valid` and `cpu_req_ready` are low. The snoop updates the line first, and the request is re-evaluated from the new state, so an invalidate becomes a read-for-ownership.
- R11: With `MSI_MODE` = 1 no line is ever Exclusive. Read fills are Shared whatever `bus_shared_in` is, and a later write issues an invalidate.
- R12: `bus_req_valid` is only high while `cpu_req_valid` is high, and it stays high, cycle after cycle, until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_req_ready | output | 1 | Request completes at this edge |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus transaction |
| bus_grant | input | 1 | Bus owned this cycle; transaction takes place at this edge |
| bus_shared_in | input | 1 | Wired-OR copy-present line, sampled in the grant cycle |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Snooped command, same encoding as `bus_req_cmd` |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_shared_out | output | 1 | This cache holds the snooped line (one cycle after the snoop) |
| snoop_supply_out | output | 1 | This cache supplies dirty data and writes it back (one cycle after the snoop) |

## Verification
A wrong line state is only visible at the ports through the next access or the next snoop to that set. A line wrongly left Exclusive lets a write finish with no invalidate. A line wrongly Shared produces a needless invalidate. A lost Modified state shows as a missing `snoop_supply_out` one cycle after a snoop, or as a missing write-back when the set is replaced. The directed scenarios therefore follow every state change with a probe access or snoop that tells the possible states apart within one or two cycles.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_INV = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_t;

endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
  import coh_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  // read port a: processor lookup
  input  logic [IDX_W-1:0]      rd_a_idx,
  output logic [TAG_W-1:0]      rd_a_tag,
  output line_st_t              rd_a_st,
  // read port b: snoop lookup
  input  logic [IDX_W-1:0]      rd_b_idx,
  output logic [TAG_W-1:0]      rd_b_tag,
  output line_st_t              rd_b_st,
  // write port a: processor side, tag and state
  input  logic                  wr_a_en,
  input  logic [IDX_W-1:0]      wr_a_idx,
  input  logic [TAG_W-1:0]      wr_a_tag,
  input  line_st_t              wr_a_st,
  // write port b: snoop side, state only
  input  logic                  wr_b_en,
  input  logic [IDX_W-1:0]      wr_b_idx,
  input  line_st_t              wr_b_st,
  output logic [SETS-1:0][1:0]  st_all
);

  logic [TAG_W-1:0] tag_q [SETS];
  line_st_t         st_q  [SETS];

  for (genvar i = 0; i < SETS; i++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_I;
      end else if (wr_a_en && wr_a_idx == IDX_W'(i)) begin
        tag_q[i] <= wr_a_tag;
        st_q[i]  <= wr_a_st;
      end else if (wr_b_en && wr_b_idx == IDX_W'(i)) begin
        st_q[i]  <= wr_b_st;
      end
    end
    assign st_all[i] = st_q[i];
  end

  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_a_st  = st_q[rd_a_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign rd_b_st  = st_q[rd_b_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snoop_valid,
  input  bus_cmd_t         snoop_cmd,
  input  logic [TAG_W-1:0] snoop_tag,
  input  logic [TAG_W-1:0] lk_tag,
  input  line_st_t         lk_st,
  output logic             wr_en,
  output line_st_t         wr_st,
  output logic             shared_q,
  output logic             supply_q
);

  logic hit;

  assign hit   = snoop_valid && (snoop_cmd != BC_WB) &&
                 (lk_st != ST_I) && (lk_tag == snoop_tag);
  assign wr_st = (snoop_cmd == BC_RD) ? ST_S : ST_I;
  assign wr_en = hit && (lk_st != wr_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q <= 1'b0;
      supply_q <= 1'b0;
    end else begin
      shared_q <= hit;
      supply_q <= hit && (lk_st == ST_M);
    end
  end

  // R6
  supply_with_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_q |-> shared_q);

endmodule

// File: rtl/coh_req_unit.sv
module coh_req_unit
  import coh_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 8,
  parameter bit MSI_MODE = 1'b0
) (
  input  logic                   cpu_valid,
  input  logic                   cpu_write,
  input  logic [IDX_W-1:0]       cpu_idx,
  input  logic [TAG_W-1:0]       cpu_tag,
  input  logic [TAG_W-1:0]       lk_tag,
  input  line_st_t               lk_st,
  input  logic                   block,
  input  logic                   bus_grant,
  input  logic                   bus_shared,
  output logic                   cpu_ready,
  output logic                   bus_valid,
  output bus_cmd_t               bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  output logic                   wr_en,
  output logic [TAG_W-1:0]       wr_tag,
  output line_st_t               wr_st
);

  logic present;
  logic owned;

  assign present = (lk_st != ST_I) && (lk_tag == cpu_tag);
  assign owned   = (lk_st == ST_E) || (lk_st == ST_M);

  always_comb begin
    cpu_ready = 1'b0;
    bus_valid = 1'b0;
    bus_cmd   = BC_RD;
    bus_addr  = {cpu_tag, cpu_idx};
    wr_en     = 1'b0;
    wr_tag    = cpu_tag;
    wr_st     = ST_I;
    if (cpu_valid && !block) begin
      if (present && !cpu_write) begin
        cpu_ready = 1'b1;
      end else if (present && owned) begin
        cpu_ready = 1'b1;
        wr_en     = (lk_st == ST_E);
        wr_st     = ST_M;
      end else begin
        bus_valid = 1'b1;
        if (present) begin
          bus_cmd = BC_INV;
        end else if (lk_st == ST_M) begin
          bus_cmd  = BC_WB;
          bus_addr = {lk_tag, cpu_idx};
        end else begin
          bus_cmd = cpu_write ? BC_RDX : BC_RD;
        end
        if (bus_grant) begin
          wr_en = 1'b1;
          unique case (bus_cmd)
            BC_WB: begin
              wr_tag = lk_tag;
              wr_st  = ST_I;
            end
            BC_RD: begin
              cpu_ready = 1'b1;
              wr_st     = (MSI_MODE || bus_shared) ? ST_S : ST_E;
            end
            default: begin
              cpu_ready = 1'b1;
              wr_st     = ST_M;
            end
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int SETS     = 16,
  parameter bit MSI_MODE = 1'b0,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_cmd,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared_out,
  output logic              snoop_supply_out
);

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic [TAG_W-1:0] lk_a_tag, lk_b_tag, req_wr_tag;
  line_st_t         lk_a_st, lk_b_st, req_wr_st, snp_wr_st;
  logic             req_wr_en, snp_wr_en, snoop_conflict;
  bus_cmd_t         req_cmd;
  logic [SETS-1:0][1:0] st_all;

  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

  // a snoop to the set being requested is applied before the request
  assign snoop_conflict = snoop_valid && (snp_idx == cpu_idx);

  coh_state_array #(.SETS(SETS), .TAG_W(TAG_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (cpu_idx),
    .rd_a_tag (lk_a_tag),
    .rd_a_st  (lk_a_st),
    .rd_b_idx (snp_idx),
    .rd_b_tag (lk_b_tag),
    .rd_b_st  (lk_b_st),
    .wr_a_en  (req_wr_en),
    .wr_a_idx (cpu_idx),
    .wr_a_tag (req_wr_tag),
    .wr_a_st  (req_wr_st),
    .wr_b_en  (snp_wr_en),
    .wr_b_idx (snp_idx),
    .wr_b_st  (snp_wr_st),
    .st_all   (st_all)
  );

  coh_req_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .MSI_MODE(MSI_MODE)) u_req (
    .cpu_valid  (cpu_req_valid),
    .cpu_write  (cpu_req_write),
    .cpu_idx    (cpu_idx),
    .cpu_tag    (cpu_tag),
    .lk_tag     (lk_a_tag),
    .lk_st      (lk_a_st),
    .block      (snoop_conflict),
    .bus_grant  (bus_grant),
    .bus_shared (bus_shared_in),
    .cpu_ready  (cpu_req_ready),
    .bus_valid  (bus_req_valid),
    .bus_cmd    (req_cmd),
    .bus_addr   (bus_req_addr),
    .wr_en      (req_wr_en),
    .wr_tag     (req_wr_tag),
    .wr_st      (req_wr_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .clk         (clk),
    .rst_n       (rst_n),
    .snoop_valid (snoop_valid),
    .snoop_cmd   (bus_cmd_t'(snoop_cmd)),
    .snoop_tag   (snp_tag),
    .lk_tag      (lk_b_tag),
    .lk_st       (lk_b_st),
    .wr_en       (snp_wr_en),
    .wr_st       (snp_wr_st),
    .shared_q    (snoop_shared_out),
    .supply_q    (snoop_supply_out)
  );

  assign bus_req_cmd = req_cmd;

  // R12
  bus_req_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> cpu_req_valid);

  // R10
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_conflict |-> (!bus_req_valid && !cpu_req_ready));

  // R5
  write_leaves_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_write)
      |=> (st_all[$past(cpu_idx)] == 2'(ST_M)));

  // R11
  msi_no_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    MSI_MODE |-> (st_all[cpu_idx] != 2'(ST_E) && st_all[snp_idx] != 2'(ST_E)));

endmodule

// File: tb/coh_snoop_ctrl_bench.sv
module coh_snoop_ctrl_bench;

  localparam int ADDR_W = 12;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_INV = 2'd2, C_WB = 2'd3;
  localparam logic [ADDR_W-1:0] A_A = 12'h013, A_B = 12'h023, A_C = 12'h035,
                                A_D = 12'h047, A_E = 12'h05A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic bus_grant = 1'b0, bus_shared_in = 1'b0;
  logic snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'd0;
  logic [ADDR_W-1:0] snoop_addr = '0;

  logic rdy0, bv0, sh0, sp0, rdy1, bv1, sh1, sp1;
  logic [1:0] bc0, bc1;
  logic [ADDR_W-1:0] ba0, ba1;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  coh_snoop_ctrl #(.ADDR_W(ADDR_W), .SETS(16), .MSI_MODE(1'b0)) u_coh_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_ready(rdy0),
    .bus_req_valid(bv0), .bus_req_cmd(bc0), .bus_req_addr(ba0),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_shared_out(sh0), .snoop_supply_out(sp0)
  );

  coh_snoop_ctrl #(.ADDR_W(ADDR_W), .SETS(16), .MSI_MODE(1'b1)) u_coh_snoop_ctrl_msi (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_ready(rdy1),
    .bus_req_valid(bv1), .bus_req_cmd(bc1), .bus_req_addr(ba1),
    .bus_grant(bus_grant), .bus_shared_in(bus_shared_in),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .snoop_shared_out(sh1), .snoop_supply_out(sp1)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // present a processor request with no grant; outputs settle 1 ns later
  task automatic probe(input logic w, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
    bus_grant = 1'b0; snoop_valid = 1'b0;
    #1;
  endtask

  // grant the bus in the current cycle; caller checks, then commit
  task automatic grant(input logic sh);
    bus_grant = 1'b1; bus_shared_in = sh;
    #1;
  endtask

  task automatic commit();
    @(posedge clk);
    #1;
  endtask

  task automatic release_req();
    @(negedge clk);
    cpu_req_valid = 1'b0; bus_grant = 1'b0; bus_shared_in = 1'b0;
  endtask

  // one snoop cycle; returns with the registered response visible
  task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = c; snoop_addr = a;
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset_and_read_fill();
    probe(1'b0, A_A);
    chk("R1", "bus_req_valid after reset", bv0, 1);
    chk("R1", "cpu_req_ready after reset", rdy0, 0);
    chk("R2", "read miss cmd", bc0, C_RD);
    chk("R2", "read miss addr", ba0, A_A);
    @(negedge clk); #1;
    chk("R12", "request held without grant", bv0, 1);
    chk("R12", "command held without grant", bc0, C_RD);
    grant(1'b0);
    chk("R2", "ready in grant cycle", rdy0, 1);
    commit();
    release_req();
    probe(1'b0, A_A);
    chk("R3", "read hit ready", rdy0, 1);
    chk("R3", "read hit no bus", bv0, 0);
    release_req();
  endtask

  task automatic t_silent_write_and_snoop_read();
    probe(1'b1, A_A);
    chk("R4", "write to exclusive ready", rdy0, 1);
    chk("R4", "write to exclusive no bus", bv0, 0);
    commit();
    release_req();
    snoop(C_RD, A_A);
    chk("R6", "snoop read on modified shared_out", sh0, 1);
    chk("R6", "snoop read on modified supply_out", sp0, 1);
    probe(1'b1, A_A);
    chk("R6", "line now shared: write issues invalidate", bc0, C_INV);
    chk("R6", "write to shared not ready", rdy0, 0);
  endtask

  task automatic t_pending_invalidate_overtaken();
    // request pending from previous task: invalidate on A_A
    @(negedge clk);
    snoop_valid = 1'b1; snoop_cmd = C_INV; snoop_addr = A_A;
    #1;
    chk("R10", "bus request withdrawn during snoop", bv0, 0);
    chk("R10", "cpu not ready during snoop", rdy0, 0);
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk("R7", "snoop invalidate shared_out", sh0, 1);
    chk("R7", "snoop invalidate on shared no supply", sp0, 0);
    chk("R10", "request re-evaluated as write miss", bc0, C_RDX);
    chk("R10", "re-evaluated request valid", bv0, 1);
    grant(1'b1);
    chk("R5", "write miss ready on grant", rdy0, 1);
    commit();
    release_req();
    probe(1'b1, A_A);
    chk("R5", "after ownership write is silent", bv0, 0);
    commit();
    release_req();
  endtask

  task automatic t_dirty_eviction();
    probe(1'b0, A_B);
    chk("R9", "eviction cmd", bc0, C_WB);
    chk("R9", "eviction addr is victim", ba0, A_A);
    grant(1'b0);
    chk("R9", "write-back does not complete request", rdy0, 0);
    commit();
    chk("R9", "miss follows write-back", bc0, C_RD);
    chk("R9", "miss addr", ba0, A_B);
    @(negedge clk);
    grant(1'b1);
    chk("R3", "shared fill ready", rdy0, 1);
    commit();
    release_req();
    snoop(C_RDX, A_A);
    chk("R8", "snoop tag mismatch shared_out", sh0, 0);
    chk("R8", "snoop tag mismatch supply_out", sp0, 0);
    probe(1'b0, A_B);
    chk("R8", "resident line untouched by mismatch", rdy0, 1);
    release_req();
    probe(1'b1, A_B);
    chk("R3", "shared fill: write issues invalidate", bc0, C_INV);
    release_req();
    snoop(C_RDX, A_B);
    chk("R7", "snoop rdx on shared shared_out", sh0, 1);
    chk("R7", "snoop rdx on shared supply_out", sp0, 0);
    probe(1'b0, A_B);
    chk("R7", "line invalid after rdx: read misses", bc0, C_RD);
    chk("R7", "line invalid after rdx: not ready", rdy0, 0);
    release_req();
  endtask

  task automatic t_writeback_snoop_ignored();
    probe(1'b0, A_C);
    grant(1'b0);
    commit();
    release_req();
    snoop(C_WB, A_C);
    chk("R8", "snooped write-back shared_out", sh0, 0);
    chk("R8", "snooped write-back supply_out", sp0, 0);
    probe(1'b1, A_C);
    chk("R8", "line still exclusive after write-back snoop", rdy0, 1);
    chk("R8", "no bus after write-back snoop", bv0, 0);
    commit();
    release_req();
    snoop(C_RDX, A_C);
    chk("R7", "snoop rdx on modified supply_out", sp0, 1);
    chk("R7", "snoop rdx on modified shared_out", sh0, 1);
    probe(1'b0, A_C);
    chk("R7", "modified line dropped to invalid", bc0, C_RD);
    release_req();
  endtask

  task automatic t_exclusive_downgrade();
    probe(1'b0, A_D);
    grant(1'b0);
    commit();
    release_req();
    snoop(C_RD, A_D);
    chk("R6", "snoop read on exclusive shared_out", sh0, 1);
    chk("R6", "snoop read on exclusive supply_out", sp0, 0);
    probe(1'b1, A_D);
    chk("R6", "exclusive downgraded: invalidate", bc0, C_INV);
    release_req();
  endtask

  task automatic t_msi_mode();
    probe(1'b0, A_E);
    chk("R11", "msi read miss cmd", bc1, C_RD);
    grant(1'b0);
    chk("R11", "msi read ready", rdy1, 1);
    commit();
    release_req();
    probe(1'b1, A_E);
    chk("R11", "msi fill is shared: invalidate", bc1, C_INV);
    chk("R11", "msi write not ready", rdy1, 0);
    chk("R3", "mesi twin exclusive: silent write", rdy0, 1);
    grant(1'b0);
    chk("R11", "msi invalidate ready on grant", rdy1, 1);
    commit();
    release_req();
    probe(1'b1, A_E);
    chk("R11", "msi modified write silent", bv1, 0);
    commit();
    release_req();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_read_fill();
    t_silent_write_and_snoop_read();
    t_pending_invalidate_overtaken();
    t_dirty_eviction();
    t_writeback_snoop_ignored();
    t_exclusive_downgrade();
    t_msi_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule